// File: doc/BRIEF.md
# Bus ROM Search Master Engine

This block sits on the master side of a shared single-wire, open-drain bus. Its job is to list the 64-bit identifiers of the devices hanging on that bus. Each accepted start request runs one search pass and returns one identifier.

The engine does not time bus slots itself. It asks a bit-level transaction engine for four kinds of operation:
- a bus reset with presence sampling,
- a byte write,
- a single bit read,
- a single bit write.

Within a pass, every identifier bit is worked out from two reads. The first read gives the wired-AND of the participating devices' true bits and the second gives the wired-AND of their complements. The engine then writes back the branch it has chosen.

Between passes the engine keeps two things: the position of the last unresolved discrepancy and the previous identifier. Successive passes therefore walk the whole population, ending with a last-device flag. A pass in which devices vanish, or in which nobody answers the reset, ends with a no-device flag. A normal search or an alarm-only search can be chosen for each pass.

The transaction request port is valid/ready. The engine holds `txn_valid_o`, `txn_op_o` and `txn_wdata_o` steady until `txn_ready_i` is sampled high, and only then waits for exactly one response. Responses (`rsp_valid_i`) and results (`done_o`) carry no back-pressure. A result stays on its pins until the next start is accepted. Start requests are accepted only while `start_ready_o` is high, which means the engine is idle.

Top module: `rom_search_master`

## Requirements
- R1: After reset the engine is idle: `start_ready_o`=1, `txn_valid_o`=0, `done_o`=0, `last_dev_o`=0, `no_dev_o`=0, `id_o`=0, and the stored discrepancy position is zero (no previous pass).
- R2: A pass issues transactions in this order:
  - a reset (op 0),
  - a byte write (op 1) carrying 0xF0 when `alarm_i` was low at start, or 0xEC when it was high,
  - then, for each bit index 0 to ID_W-1, a read (op 2) of the true bit, a read (op 2) of the complement bit, and a bit write (op 3) with the branch in `txn_wdata_o[0]` and zeros above it.
- R3: A request keeps valid, op and data stable until accepted. The engine then waits for one response. For a reset, `rsp_bit_i`=1 means presence.
- R4: A true/complement pair of 0/1 selects branch 0 and a pair of 1/0 selects branch 1. The chosen branch of bit index i is stored in `id_o[i]`, so the first resolved bit lands at bit 0.
- R5: A 0/0 pair at 1-based position p, compared with the stored discrepancy position L, is resolved as follows. Every 0/0 pair resolved to 0 records p as the newest zero-branch discrepancy.
  - p<L: repeat the previous identifier's bit.
  - p=L: take 1.
  - p>L: take 0.
- R6: A 1/1 pair, or a reset without presence, ends the pass at once with `done_o` and `no_dev_o`=1 and `last_dev_o`=0. The stored position and the previous identifier keep their values.
- R7: A completed pass stores its newest zero-branch discrepancy as L. When that value is zero it sets `last_dev_o`, and the next start behaves as a first search.
- R8: `first_i` high while idle clears L and `last_dev_o`. The next pass then returns the first identifier again.
- R9: `done_o` is a one-cycle pulse. Accepting a start clears `no_dev_o` and `last_dev_o`, and no transaction is requested while idle.
- R10: An alarm-only pass enumerates only the devices that answer 0xEC, in the same order and with the same last-device rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid_i | input | 1 | Request one search pass |
| start_ready_o | output | 1 | Engine idle, start accepted |
| alarm_i | input | 1 | Pass mode sampled at start: 1 selects the alarm-only search |
| first_i | input | 1 | Restart the enumeration (honoured while idle) |
| txn_valid_o | output | 1 | Transaction request valid |
| txn_ready_i | input | 1 | Transaction request accepted |
| txn_op_o | output | 2 | 0 reset, 1 byte write, 2 bit read, 3 bit write |
| txn_wdata_o | output | 8 | Byte for op 1, branch in bit 0 for op 3 |
| rsp_valid_i | input | 1 | Transaction completed |
| rsp_bit_i | input | 1 | Presence for op 0, sampled bit for op 2 |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| id_o | output | ID_W | Identifier found, bit 0 resolved first |
| last_dev_o | output | 1 | Last identifier in the enumeration |
| no_dev_o | output | 1 | Pass aborted: no device responded |

## Verification
The bound assertions check these rules on every cycle:
- request stability under back-pressure,
- the single-cycle done pulse,
- the quiet request port while idle,
- the clearing of flags on start and on `first_i`,
- the zero upper bits of branch writes,
- the rule that an aborted pass never reports a last device.

Only the bench's scenarios can show the rest: that the returned identifiers and their order are right for many device populations, that the stored discrepancy state survives an aborted pass, and that the alarm filter restricts the enumeration. The bench does this with a wired-AND device model and expected orders sorted by bit-reversed identifier.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WBYTE = 2'd1,
    OP_RBIT  = 2'd2,
    OP_WBIT  = 2'd3
  } rsm_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_REQ,
    S_RST_WAIT,
    S_CMD_REQ,
    S_CMD_WAIT,
    S_RDT_REQ,
    S_RDT_WAIT,
    S_RDC_REQ,
    S_RDC_WAIT,
    S_WR_REQ,
    S_WR_WAIT
  } rsm_state_e;

  localparam logic [7:0] CMD_SEARCH_ALL   = 8'hF0;
  localparam logic [7:0] CMD_SEARCH_ALARM = 8'hEC;

endpackage

// File: rtl/rsm_branch.sv
// Branch decision for one identifier bit from the true/complement pair.
module rsm_branch #(
  parameter int POS_W = 7
) (
  input  logic             t_bit_i,
  input  logic             c_bit_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] last_disc_i,
  input  logic             prev_bit_i,
  output logic             dir_o,
  output logic             none_o,
  output logic             zero_disc_o
);

  logic clash;

  assign clash  = ~t_bit_i & ~c_bit_i;
  assign none_o = t_bit_i & c_bit_i;

  always_comb begin
    dir_o = t_bit_i;
    if (clash) begin
      if (pos_i < last_disc_i)       dir_o = prev_bit_i;
      else if (pos_i == last_disc_i) dir_o = 1'b1;
      else                           dir_o = 1'b0;
    end
  end

  assign zero_disc_o = clash & ~dir_o;

endmodule

// File: rtl/rsm_idreg.sv
// Identifier under construction plus the identifier of the previous pass.
module rsm_idreg #(
  parameter int ID_W  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_bit_i,
  input  logic             commit_i,
  output logic [ID_W-1:0]  cur_o,
  output logic [ID_W-1:0]  prev_o
);

  logic [ID_W-1:0] cur_q;
  logic [ID_W-1:0] prev_q;

  for (genvar g = 0; g < ID_W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cur_q[g] <= 1'b0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    cur_q[g] <= wr_bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_q <= '0;
    else if (commit_i) prev_q <= cur_q;
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/rsm_seq.sv
// Pass sequencer: transaction ordering, per-pass and cross-pass state.
module rsm_seq
  import rsm_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int IDX_W = 6,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid_i,
  output logic             start_ready_o,
  input  logic             alarm_i,
  input  logic             first_i,
  output logic             txn_valid_o,
  input  logic             txn_ready_i,
  output logic [1:0]       txn_op_o,
  output logic [7:0]       txn_wdata_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_bit_i,
  input  logic             dir_i,
  input  logic             none_i,
  input  logic             zero_disc_i,
  output logic             tbit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] last_disc_o,
  output logic             id_wr_o,
  output logic             id_commit_o,
  output logic             done_o,
  output logic             last_dev_o,
  output logic             no_dev_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_W - 1);

  rsm_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             tbit_q;
  logic             dir_q;
  logic [7:0]       cmd_q;
  logic [POS_W-1:0] last_disc_q;
  logic [POS_W-1:0] last_zero_q;
  logic             last_dev_q;
  logic             no_dev_q;
  logic             done_q;
  logic             start_fire;
  logic             pair_ok;
  logic             pair_bad;
  logic             bit_done;
  rsm_op_e          op;

  assign start_fire = start_valid_i && (state_q == S_IDLE);
  assign pair_ok    = (state_q == S_RDC_WAIT) && rsp_valid_i && !none_i;
  assign pair_bad   = (state_q == S_RDC_WAIT) && rsp_valid_i && none_i;
  assign bit_done   = (state_q == S_WR_WAIT) && rsp_valid_i;
  assign pos_o      = POS_W'(idx_q) + POS_W'(1);

  // Request side: one operation per request state
  always_comb begin
    txn_valid_o = 1'b1;
    op          = OP_RBIT;
    txn_wdata_o = 8'h00;
    unique case (state_q)
      S_RST_REQ: op = OP_RESET;
      S_CMD_REQ: begin
        op          = OP_WBYTE;
        txn_wdata_o = cmd_q;
      end
      S_RDT_REQ, S_RDC_REQ: op = OP_RBIT;
      S_WR_REQ: begin
        op          = OP_WBIT;
        txn_wdata_o = {7'b0, dir_q};
      end
      default: txn_valid_o = 1'b0;
    endcase
  end
  assign txn_op_o = op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      tbit_q      <= 1'b0;
      dir_q       <= 1'b0;
      cmd_q       <= CMD_SEARCH_ALL;
      last_disc_q <= '0;
      last_zero_q <= '0;
      last_dev_q  <= 1'b0;
      no_dev_q    <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_fire) begin
            if (first_i || last_dev_q) last_disc_q <= '0;
            last_dev_q  <= 1'b0;
            no_dev_q    <= 1'b0;
            cmd_q       <= alarm_i ? CMD_SEARCH_ALARM : CMD_SEARCH_ALL;
            idx_q       <= '0;
            last_zero_q <= '0;
            state_q     <= S_RST_REQ;
          end else if (first_i) begin
            last_disc_q <= '0;
            last_dev_q  <= 1'b0;
          end
        end
        S_RST_REQ:  if (txn_ready_i) state_q <= S_RST_WAIT;
        S_RST_WAIT: begin
          if (rsp_valid_i) begin
            if (rsp_bit_i) begin
              state_q <= S_CMD_REQ;
            end else begin
              no_dev_q <= 1'b1;
              done_q   <= 1'b1;
              state_q  <= S_IDLE;
            end
          end
        end
        S_CMD_REQ:  if (txn_ready_i) state_q <= S_CMD_WAIT;
        S_CMD_WAIT: if (rsp_valid_i) state_q <= S_RDT_REQ;
        S_RDT_REQ:  if (txn_ready_i) state_q <= S_RDT_WAIT;
        S_RDT_WAIT: begin
          if (rsp_valid_i) begin
            tbit_q  <= rsp_bit_i;
            state_q <= S_RDC_REQ;
          end
        end
        S_RDC_REQ:  if (txn_ready_i) state_q <= S_RDC_WAIT;
        S_RDC_WAIT: begin
          if (pair_bad) begin
            no_dev_q <= 1'b1;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end else if (pair_ok) begin
            dir_q <= dir_i;
            if (zero_disc_i) last_zero_q <= pos_o;
            state_q <= S_WR_REQ;
          end
        end
        S_WR_REQ:   if (txn_ready_i) state_q <= S_WR_WAIT;
        S_WR_WAIT: begin
          if (bit_done) begin
            if (idx_q == LAST_IDX) begin
              last_disc_q <= last_zero_q;
              last_dev_q  <= (last_zero_q == '0);
              done_q      <= 1'b1;
              state_q     <= S_IDLE;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= S_RDT_REQ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign start_ready_o = (state_q == S_IDLE);
  assign tbit_o        = tbit_q;
  assign idx_o         = idx_q;
  assign last_disc_o   = last_disc_q;
  assign id_wr_o       = pair_ok;
  assign id_commit_o   = bit_done && (idx_q == LAST_IDX);
  assign done_o        = done_q;
  assign last_dev_o    = last_dev_q;
  assign no_dev_o      = no_dev_q;

endmodule

// File: rtl/rom_search_master.sv
// Top: ROM search master engine over a bit-level transaction port.
module rom_search_master #(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_valid_i,
  output logic            start_ready_o,
  input  logic            alarm_i,
  input  logic            first_i,
  output logic            txn_valid_o,
  input  logic            txn_ready_i,
  output logic [1:0]      txn_op_o,
  output logic [7:0]      txn_wdata_o,
  input  logic            rsp_valid_i,
  input  logic            rsp_bit_i,
  output logic            done_o,
  output logic [ID_W-1:0] id_o,
  output logic            last_dev_o,
  output logic            no_dev_o
);

  localparam int IDX_W = (ID_W > 2) ? $clog2(ID_W) : 1;
  localparam int POS_W = IDX_W + 1;

  logic             dir;
  logic             none;
  logic             zero_disc;
  logic             tbit;
  logic [IDX_W-1:0] idx;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] last_disc;
  logic             id_wr;
  logic             id_commit;
  logic [ID_W-1:0]  cur_id;
  logic [ID_W-1:0]  prev_id;

  rsm_seq #(
    .ID_W (ID_W),
    .IDX_W(IDX_W),
    .POS_W(POS_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_valid_i(start_valid_i),
    .start_ready_o(start_ready_o),
    .alarm_i      (alarm_i),
    .first_i      (first_i),
    .txn_valid_o  (txn_valid_o),
    .txn_ready_i  (txn_ready_i),
    .txn_op_o     (txn_op_o),
    .txn_wdata_o  (txn_wdata_o),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_bit_i    (rsp_bit_i),
    .dir_i        (dir),
    .none_i       (none),
    .zero_disc_i  (zero_disc),
    .tbit_o       (tbit),
    .idx_o        (idx),
    .pos_o        (pos),
    .last_disc_o  (last_disc),
    .id_wr_o      (id_wr),
    .id_commit_o  (id_commit),
    .done_o       (done_o),
    .last_dev_o   (last_dev_o),
    .no_dev_o     (no_dev_o)
  );

  rsm_branch #(
    .POS_W(POS_W)
  ) u_branch (
    .t_bit_i    (tbit),
    .c_bit_i    (rsp_bit_i),
    .pos_i      (pos),
    .last_disc_i(last_disc),
    .prev_bit_i (prev_id[idx]),
    .dir_o      (dir),
    .none_o     (none),
    .zero_disc_o(zero_disc)
  );

  rsm_idreg #(
    .ID_W (ID_W),
    .IDX_W(IDX_W)
  ) u_idreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (id_wr),
    .wr_idx_i(idx),
    .wr_bit_i(dir),
    .commit_i(id_commit),
    .cur_o   (cur_id),
    .prev_o  (prev_id)
  );

  assign id_o = cur_id;

endmodule

// File: rtl/rsm_checker.sv
module rsm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_valid_i,
  input logic       start_ready_o,
  input logic       first_i,
  input logic       txn_valid_o,
  input logic       txn_ready_i,
  input logic [1:0] txn_op_o,
  input logic [7:0] txn_wdata_o,
  input logic       done_o,
  input logic       last_dev_o,
  input logic       no_dev_o
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_TXN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_op_o) && $stable(txn_wdata_o)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready_o |-> !txn_valid_o); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid_i && start_ready_o |=> !no_dev_o && !last_dev_o && !start_ready_o); // R9

  AST_ABORT_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && no_dev_o |-> !last_dev_o); // R6

  AST_FIRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    first_i && start_ready_o |=> !last_dev_o); // R8

  AST_WBIT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid_o && txn_op_o == 2'd3 |-> txn_wdata_o[7:1] == 7'd0); // R2

endmodule

bind rom_search_master rsm_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_valid_i(start_valid_i),
  .start_ready_o(start_ready_o),
  .first_i      (first_i),
  .txn_valid_o  (txn_valid_o),
  .txn_ready_i  (txn_ready_i),
  .txn_op_o     (txn_op_o),
  .txn_wdata_o  (txn_wdata_o),
  .done_o       (done_o),
  .last_dev_o   (last_dev_o),
  .no_dev_o     (no_dev_o)
);

// File: tb/sim_rom_search_master.sv
module sim_rom_search_master;
  localparam int W  = 8;
  localparam int ND = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         start_valid = 1'b0, alarm = 1'b0, first = 1'b0;
  logic         txn_ready = 1'b0, rsp_valid = 1'b0, rsp_bit = 1'b0;
  logic         start_ready, txn_valid, done, last_dev, no_dev;
  logic [1:0]   txn_op;
  logic [7:0]   txn_wdata;
  logic [W-1:0] id;

  rom_search_master #(.ID_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_valid_i(start_valid), .start_ready_o(start_ready),
    .alarm_i(alarm), .first_i(first), .txn_valid_o(txn_valid), .txn_ready_i(txn_ready),
    .txn_op_o(txn_op), .txn_wdata_o(txn_wdata), .rsp_valid_i(rsp_valid), .rsp_bit_i(rsp_bit),
    .done_o(done), .id_o(id), .last_dev_o(last_dev), .no_dev_o(no_dev)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Wired-AND device population model
  logic [W-1:0] dev_id[ND];
  logic         dev_on[ND], dev_alm[ND], dev_act[ND];
  int           yank_at = -1;
  int           kbit = 0;
  int           exp_ph = 0;
  int           lat_ctr = 0;
  logic [7:0]   exp_cmd = 8'hF0;

  initial begin
    for (int i = 0; i < ND; i++) begin
      dev_on[i] = 0; dev_alm[i] = 0; dev_act[i] = 0; dev_id[i] = '0;
    end
  end

  initial begin : responder
    logic [1:0] op;
    logic [7:0] wd;
    logic       rb;
    forever begin
      @(negedge clk);
      if (rst_n && txn_valid) begin
        op = txn_op; wd = txn_wdata;
        txn_ready = 1'b1;
        @(negedge clk);
        txn_ready = 1'b0;
        rb = 1'b0;
        case (op)
          2'd0: begin
            rb = 1'b0;
            for (int i = 0; i < ND; i++) begin
              dev_act[i] = dev_on[i];
              if (dev_on[i]) rb = 1'b1;
            end
            kbit = 0; exp_ph = 1;
          end
          2'd1: begin
            chk(exp_ph == 1 && wd == exp_cmd, "R2 command byte", wd, exp_cmd);
            if (wd == 8'hEC)
              for (int i = 0; i < ND; i++) dev_act[i] = dev_act[i] & dev_alm[i];
            exp_ph = 2;
          end
          2'd2: begin
            chk(exp_ph == 2 || exp_ph == 3, "R2 read order", exp_ph, 2);
            if (yank_at == kbit)
              for (int i = 0; i < ND; i++) dev_act[i] = 1'b0;
            rb = 1'b1;
            for (int i = 0; i < ND; i++)
              if (dev_act[i]) rb = rb & ((exp_ph == 2) ? dev_id[i][kbit] : ~dev_id[i][kbit]);
            exp_ph++;
          end
          default: begin
            chk(exp_ph == 4 && wd[7:1] == 0, "R2 bit write order", exp_ph, 4);
            for (int i = 0; i < ND; i++)
              if (dev_id[i][kbit] != wd[0]) dev_act[i] = 1'b0;
            kbit++; exp_ph = 2;
          end
        endcase
        repeat (lat_ctr % 3) @(negedge clk);
        lat_ctr++;
        rsp_valid = 1'b1; rsp_bit = rb;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  function automatic logic [W-1:0] brev(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) brev[i] = v[W-1-i];
  endfunction

  task automatic clear_devs();
    for (int i = 0; i < ND; i++) begin dev_on[i] = 0; dev_alm[i] = 0; end
  endtask

  task automatic run_pass(input logic alm, output logic [W-1:0] rid, output logic ld, output logic nd);
    int n;
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1; alarm = alm;
    exp_cmd = alm ? 8'hEC : 8'hF0;
    @(negedge clk);
    start_valid = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(0, "R9 no done pulse", 0, 1);
    rid = id; ld = last_dev; nd = no_dev;
  endtask

  // Full enumeration of the current population; expected order by bit-reversed id
  task automatic enumerate(input logic alm, input string tag);
    logic [W-1:0] ex[ND];
    int m;
    logic [W-1:0] rid;
    logic ld, nd;
    m = 0;
    for (int i = 0; i < ND; i++)
      if (dev_on[i] && (!alm || dev_alm[i])) begin ex[m] = dev_id[i]; m++; end
    for (int i = 0; i < m; i++)
      for (int j = i + 1; j < m; j++)
        if (brev(ex[j]) < brev(ex[i])) begin
          logic [W-1:0] t;
          t = ex[i]; ex[i] = ex[j]; ex[j] = t;
        end
    for (int p = 0; p < m; p++) begin
      run_pass(alm, rid, ld, nd);
      chk(rid == ex[p], {tag, " id order"}, rid, ex[p]);
      chk(ld == (p == m - 1), "R7 last flag", ld, (p == m - 1));
      chk(nd == 1'b0, "R6 spurious abort", nd, 0);
    end
    run_pass(alm, rid, ld, nd);
    chk(rid == ex[0], "R7 restart after last", rid, ex[0]);
    // drain so the population is left at a clean state
    for (int p = 1; p < m; p++) run_pass(alm, rid, ld, nd);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [W-1:0] rid;
    logic ld, nd;
    int seed;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(start_ready == 1, "R1 start_ready", start_ready, 1);
    chk(txn_valid == 0, "R1 txn_valid", txn_valid, 0);
    chk(done == 0 && last_dev == 0 && no_dev == 0, "R1 flags", {done, last_dev, no_dev}, 0);
    chk(id == 0, "R1 id", id, 0);

    // R4: every single-device identifier, bit 0 first
    for (int v = 0; v < (1 << W); v++) begin
      clear_devs(); dev_on[0] = 1; dev_id[0] = v[W-1:0];
      run_pass(1'b0, rid, ld, nd);
      chk(rid == v[W-1:0], "R4 single id", rid, v);
      chk(ld == 1 && nd == 0, "R7 single last", {ld, nd}, 2);
    end

    // R5: populations of 2..8 distinct identifiers
    seed = 12345;
    for (int s = 0; s < 24; s++) begin
      int n;
      n = 2 + s % 7;
      clear_devs();
      for (int i = 0; i < n; i++) begin
        bit dup;
        do begin
          seed = seed * 1103515245 + 12345;
          dev_id[i] = seed[23:16];
          dup = 0;
          for (int j = 0; j < i; j++) if (dev_id[j] == dev_id[i]) dup = 1;
        end while (dup);
        dev_on[i] = 1;
      end
      enumerate(1'b0, "R5");
    end

    // R5 fixed clash pattern
    clear_devs();
    dev_id[0] = 8'h00; dev_id[1] = 8'hFF; dev_id[2] = 8'h0F; dev_id[3] = 8'hF0;
    for (int i = 0; i < 4; i++) dev_on[i] = 1;
    enumerate(1'b0, "R5 fixed");

    // R10 alarm-only search, then full search on same population
    clear_devs();
    dev_id[0] = 8'h12; dev_id[1] = 8'h34; dev_id[2] = 8'h56;
    dev_id[3] = 8'h78; dev_id[4] = 8'h9A; dev_id[5] = 8'hBC;
    for (int i = 0; i < 6; i++) dev_on[i] = 1;
    dev_alm[1] = 1; dev_alm[3] = 1; dev_alm[4] = 1;
    enumerate(1'b1, "R10 alarm");
    enumerate(1'b0, "R10 normal");

    // R8 first_i restart; ids 0x01 0x02 0x03 -> order 0x02 0x01 0x03
    clear_devs();
    dev_id[0] = 8'h01; dev_id[1] = 8'h02; dev_id[2] = 8'h03;
    for (int i = 0; i < 3; i++) dev_on[i] = 1;
    run_pass(1'b0, rid, ld, nd);
    chk(rid == 8'h02, "R8 first pass", rid, 8'h02);
    run_pass(1'b0, rid, ld, nd);
    chk(rid == 8'h01, "R8 second pass", rid, 8'h01);
    @(negedge clk); first = 1'b1; @(negedge clk); first = 1'b0;
    run_pass(1'b0, rid, ld, nd);
    chk(rid == 8'h02, "R8 restart after first_i", rid, 8'h02);
    run_pass(1'b0, rid, ld, nd);
    run_pass(1'b0, rid, ld, nd);
    chk(ld == 1, "R7 last before first_i", ld, 1);
    @(negedge clk); first = 1'b1; @(negedge clk); first = 1'b0; @(negedge clk);
    chk(last_dev == 0, "R8 first_i clears last flag", last_dev, 0);

    // R6 abort mid-pass keeps stored state
    @(negedge clk); first = 1'b1; @(negedge clk); first = 1'b0;
    run_pass(1'b0, rid, ld, nd);
    chk(rid == 8'h02, "R6 pass before abort", rid, 8'h02);
    yank_at = 3;
    run_pass(1'b0, rid, ld, nd);
    chk(nd == 1 && ld == 0, "R6 vanished devices abort", {nd, ld}, 2);
    yank_at = -1;
    run_pass(1'b0, rid, ld, nd);
    chk(rid == 8'h01 && nd == 0, "R6 state kept over abort", rid, 8'h01);

    // R6 no presence
    clear_devs();
    run_pass(1'b0, rid, ld, nd);
    chk(nd == 1 && ld == 0, "R6 no presence", {nd, ld}, 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule